// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which interrupt a small 8-bit CPU takes next. Each hardware source has its own request latch, numbered 2 to 23. A short pulse on a source's request line sets its latch. The latch stays set until the controller hands that interrupt to the CPU.

Two further sources have no latch: the software interrupt and the undefined-instruction trap. The CPU raises each of them with a strobe. Sources 2 and 3 are non-maskable. Sources 4 to 23 are maskable and need the global interrupt enable plus their own enable bit. Source 4 also needs a separate external-line enable.

In every cycle in which the CPU signals that it is ready, the controller picks the winning eligible source. On the next cycle it raises a one-cycle take pulse, together with the 16-bit vector address and the source index. On the same clock edge it clears the accepted latch and drops the global enable, so that nesting only happens when software turns the enable back on. A return-from-interrupt input turns the global enable back on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it, all latches are 0, the global enable is 0, all enable bits are 0, and take, take_vec and take_src are 0.
- R2: A 1 on irq_req[n] (n = 2..23) at a clock edge sets latch n. The latch stays pending until that source is accepted. A latch set at edge k can first be selected in the cycle that follows edge k.
- R3: Accepting latched source n clears latch n at the same edge. If irq_req[n] is 1 at that same edge, the latch stays set and the source is taken again later.
- R4: A maskable source n (4..23) is eligible only when the global enable is 1 and cfg_ef[n] is 1. Source 4 also needs cfg_ext0_en to be 1.
- R5: Latched sources 2 and 3 are eligible whenever their latch is set, whatever the global enable and the enable bits hold.
- R6: Every non-maskable source beats every maskable one. Among maskable sources, the lower index wins.
- R7: Among the non-maskable sources, the order is fixed: software interrupt (take_src 0), then undefined instruction (take_src 1), then source 2, then source 3.
- R8: The vector is FFFC for take_src 0 and 1, FFFA for source 2 and FFF8 for source 3. Sources 4 to 15 run from FFF6 down to FFE0 in steps of 2. Sources 16 to 23 run from FFBE down to FFB0 in steps of 2.
- R9: swi_strobe and undef_strobe have no latch. They count only in a cycle in which cpu_ready is 1. At any other time they have no effect.
- R10: A selection is made only when cpu_ready is 1. It appears after the next rising edge as a one-cycle take pulse. While take is 0, take_vec and take_src are 0.
- R11: Each acceptance clears the global enable. A reti pulse sets it to 1. A configuration write at the same edge overrides both.
- R12: A cfg_we pulse loads cfg_ef, cfg_ext0_en and cfg_imf into the enable state at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | LAST_SRC-1 (bits LAST_SRC..2) | Request pulses for the latched sources |
| swi_strobe | input | 1 | Software interrupt request |
| undef_strobe | input | 1 | Undefined-instruction trap request |
| cpu_ready | input | 1 | CPU can take an interrupt this cycle |
| reti | input | 1 | Return from interrupt, sets the global enable |
| cfg_we | input | 1 | Load the enable state |
| cfg_ef | input | LAST_SRC-3 (bits LAST_SRC..4) | Per-source enable bits |
| cfg_ext0_en | input | 1 | Extra enable for source 4 |
| cfg_imf | input | 1 | Global enable value to load |
| take | output | 1 | One-cycle accept pulse |
| take_vec | output | 16 | Vector address of the accepted source |
| take_src | output | SRC_W | Accepted source index (0 software, 1 undefined, 2..23 latches) |

## Verification
The bench first presents single requests while the CPU is ready and while it is busy. This shows the basic latch, select and vector path, and that the ready input gates acceptance. It then raises several maskable requests at once and takes them one per return from interrupt, which shows the priority order separately from the per-source enables. It also raises all four non-maskable sources together with the global enable off, which shows the fixed tie-break and that these sources bypass masking. A final sweep takes every latched source alone to cover the full vector map, including the jump after source 15. Requests that coincide with their own acceptance, and strobes given while the CPU is busy, show the set-over-clear rule and that strobes are not stored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int FIRST_LATCH = 2;
    localparam int FIRST_MASK  = 4;
    localparam int EXT0_SRC    = 4;
    localparam int SPLIT_SRC   = 16;
    localparam int VEC_W       = 16;

    // Vector map: strobed sources share one vector, the latched ones step down by 2
    function automatic logic [VEC_W-1:0] vec_for(input int unsigned idx);
        logic [31:0] v;
        if (idx < FIRST_LATCH)    v = 32'hFFFC;
        else if (idx < SPLIT_SRC) v = 32'hFFFE - 32'(2 * idx);
        else                      v = 32'hFFDE - 32'(2 * idx);
        return v[VEC_W-1:0];
    endfunction
endpackage

// File: rtl/irqc_latch_bank.sv
module irqc_latch_bank #(
    parameter int LAST_SRC = 23,
    parameter int SRC_W    = 5
) (
    input  logic [LAST_SRC:2] lat_q,
    input  logic [LAST_SRC:2] set_req,
    input  logic              clr_en,
    input  logic [SRC_W-1:0]  clr_idx,
    output logic [LAST_SRC:2] lat_d
);
    for (genvar n = 2; n <= LAST_SRC; n++) begin : g_lat
        logic clr;
        assign clr      = clr_en && (clr_idx == SRC_W'(n));
        // a new request wins over the acceptance clear
        assign lat_d[n] = set_req[n] | (lat_q[n] & ~clr);
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int LAST_SRC = 23,
    parameter int SRC_W    = 5
) (
    input  logic [LAST_SRC:2] lat_q,
    input  logic [LAST_SRC:4] ef,
    input  logic              ext0_en,
    input  logic              imf,
    input  logic              swi,
    input  logic              undef,
    input  logic              ready,
    output logic              hit,
    output logic [SRC_W-1:0]  idx
);
    import irqc_pkg::*;
    logic [LAST_SRC:2] elig;

    for (genvar n = 2; n <= LAST_SRC; n++) begin : g_elig
        if (n < FIRST_MASK) begin : g_nmi
            assign elig[n] = lat_q[n];
        end else if (n == EXT0_SRC) begin : g_ext0
            assign elig[n] = lat_q[n] & imf & ef[n] & ext0_en;
        end else begin : g_mask
            assign elig[n] = lat_q[n] & imf & ef[n];
        end
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (ready) begin
            for (int n = LAST_SRC; n >= 2; n--) begin
                if (elig[n]) begin
                    hit = 1'b1;
                    idx = SRC_W'(n);
                end
            end
            if (undef) begin
                hit = 1'b1;
                idx = SRC_W'(1);
            end
            if (swi) begin
                hit = 1'b1;
                idx = '0;
            end
        end
    end
endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen #(
    parameter int SRC_W = 5
) (
    input  logic [SRC_W-1:0] idx,
    output logic [15:0]      vec
);
    import irqc_pkg::*;
    assign vec = vec_for(int'(idx));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int LAST_SRC = 23,
    localparam int SRC_W   = $clog2(LAST_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAST_SRC:2] irq_req,
    input  logic              swi_strobe,
    input  logic              undef_strobe,
    input  logic              cpu_ready,
    input  logic              reti,
    input  logic              cfg_we,
    input  logic [LAST_SRC:4] cfg_ef,
    input  logic              cfg_ext0_en,
    input  logic              cfg_imf,
    output logic              take,
    output logic [15:0]       take_vec,
    output logic [SRC_W-1:0]  take_src
);
    typedef struct packed {
        logic [LAST_SRC:2] lat;
        logic [LAST_SRC:4] ef;
        logic              ext0;
        logic              imf;
        logic              take;
        logic [15:0]       vec;
        logic [SRC_W-1:0]  src;
    } state_t;

    state_t st_q, st_d;
    logic              hit;
    logic [SRC_W-1:0]  pick_idx;
    logic [15:0]       pick_vec;
    logic [LAST_SRC:2] lat_nx;
    logic              imf_q;

    irqc_pick #(.LAST_SRC(LAST_SRC), .SRC_W(SRC_W)) u_pick (
        .lat_q   (st_q.lat),
        .ef      (st_q.ef),
        .ext0_en (st_q.ext0),
        .imf     (st_q.imf),
        .swi     (swi_strobe),
        .undef   (undef_strobe),
        .ready   (cpu_ready),
        .hit     (hit),
        .idx     (pick_idx)
    );

    irqc_vecgen #(.SRC_W(SRC_W)) u_vec (
        .idx (pick_idx),
        .vec (pick_vec)
    );

    irqc_latch_bank #(.LAST_SRC(LAST_SRC), .SRC_W(SRC_W)) u_lat (
        .lat_q   (st_q.lat),
        .set_req (irq_req),
        .clr_en  (hit),
        .clr_idx (pick_idx),
        .lat_d   (lat_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lat  = lat_nx;
        st_d.take = hit;
        st_d.vec  = hit ? pick_vec : '0;
        st_d.src  = hit ? pick_idx : '0;
        if (cfg_we) begin
            st_d.ef   = cfg_ef;
            st_d.ext0 = cfg_ext0_en;
            st_d.imf  = cfg_imf;
        end else if (hit) begin
            st_d.imf  = 1'b0;
        end else if (reti) begin
            st_d.imf  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign imf_q    = st_q.imf;
    assign take     = st_q.take;
    assign take_vec = st_q.vec;
    assign take_src = st_q.src;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int SRC_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             cfg_we,
    input logic             imf_q,
    input logic             take,
    input logic [15:0]      take_vec,
    input logic [SRC_W-1:0] take_src
);
    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(cpu_ready)); // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> (take_vec == 16'h0 && take_src == '0)); // R10
    AST_IMF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!imf_q || $past(cfg_we))); // R11
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src >= SRC_W'(4)) |-> $past(imf_q)); // R4
    AST_STROBE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_src < SRC_W'(2)) |-> take_vec == 16'hFFFC); // R8
endmodule

bind irq_vector_ctrl irqc_chk #(.SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cfg_we    (cfg_we),
    .imf_q     (imf_q),
    .take      (take),
    .take_vec  (take_vec),
    .take_src  (take_src)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    localparam int PERIOD = 10;
    localparam int LAST   = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LAST:2] irq_req = '0;
    logic swi_strobe = 1'b0, undef_strobe = 1'b0, cpu_ready = 1'b0, reti = 1'b0;
    logic cfg_we = 1'b0, cfg_ext0_en = 1'b0, cfg_imf = 1'b0;
    logic [LAST:4] cfg_ef = '0;
    logic take;
    logic [15:0] take_vec;
    logic [4:0] take_src;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_lat [2:LAST];
    bit m_ef [4:LAST];
    bit m_ext0, m_imf, e_take;
    int e_src;
    logic [15:0] e_vec;

    always #(PERIOD/2) clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_strobe(swi_strobe),
        .undef_strobe(undef_strobe), .cpu_ready(cpu_ready), .reti(reti),
        .cfg_we(cfg_we), .cfg_ef(cfg_ef), .cfg_ext0_en(cfg_ext0_en), .cfg_imf(cfg_imf),
        .take(take), .take_vec(take_vec), .take_src(take_src)
    );

    function automatic logic [15:0] ref_vec(input int s);
        case (s)
            0, 1: return 16'hFFFC;
            2:    return 16'hFFFA;
            3:    return 16'hFFF8;
            default:
                if (s <= 15) return 16'(16'hFFF6 - 2 * (s - 4));
                else         return 16'(16'hFFBE - 2 * (s - 16));
        endcase
    endfunction

    function automatic bit may_take(input int s);
        if (!m_lat[s]) return 0;
        if (s < 4) return 1;
        if (!m_imf || !m_ef[s]) return 0;
        if (s == 4 && !m_ext0) return 0;
        return 1;
    endfunction

    task automatic model_edge();
        int sel = -1;
        if (!rst_n) begin
            foreach (m_lat[i]) m_lat[i] = 0;
            foreach (m_ef[i]) m_ef[i] = 0;
            m_ext0 = 0; m_imf = 0;
            e_take = 0; e_src = 0; e_vec = 0;
            return;
        end
        if (cpu_ready) begin
            if (swi_strobe) sel = 0;
            else if (undef_strobe) sel = 1;
            else begin
                for (int s = 2; s <= LAST; s++) if (sel < 0 && may_take(s)) sel = s;
            end
        end
        e_take = (sel >= 0);
        e_src  = e_take ? sel : 0;
        e_vec  = e_take ? ref_vec(sel) : 16'h0;
        for (int s = 2; s <= LAST; s++) begin
            if (irq_req[s]) m_lat[s] = 1;
            else if (sel == s) m_lat[s] = 0;
        end
        if (cfg_we) begin
            for (int s = 4; s <= LAST; s++) m_ef[s] = cfg_ef[s];
            m_ext0 = cfg_ext0_en; m_imf = cfg_imf;
        end else if (e_take) m_imf = 0;
        else if (reti) m_imf = 1;
    endtask

    // one clock: model advances with the DUT, outputs compared at the falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (take !== e_take || take_vec !== e_vec || int'(take_src) !== e_src) begin
            errors++;
            $display("FAIL %s: take=%0b vec=%h src=%0d expected take=%0b vec=%h src=%0d",
                     tag, take, take_vec, take_src, e_take, e_vec, e_src);
        end
        irq_req = '0; swi_strobe = 0; undef_strobe = 0; reti = 0; cfg_we = 0;
    endtask

    task automatic cfg(input bit imf, input bit ext0, input logic [LAST:4] ef, input string tag);
        cfg_we = 1; cfg_imf = imf; cfg_ext0_en = ext0; cfg_ef = ef;
        cyc(tag);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc("R1 reset"); cyc("R1 reset");
        rst_n = 1;
        cyc("R1 first cycle after reset");

        cfg(1, 1, '1, "R12 config load");
        // request while CPU busy, then ready
        irq_req[10] = 1; cyc("R2 latch set");
        cyc("R10 busy no take"); cyc("R10 busy no take");
        cpu_ready = 1; cyc("R8 take src 10");
        cyc("R11 imf cleared after take");
        // masked by global enable
        irq_req[5] = 1; cyc("R4 imf off");
        cyc("R4 pending masked");
        reti = 1; cyc("R11 reti restores");
        cyc("R2 take src 5 after reti");
        cyc("R10 idle");
        // non-maskable with imf off
        irq_req[3] = 1; cyc("R5 nmi set");
        cyc("R5 nmi taken with imf off");
        // priority among maskables
        reti = 1; irq_req[7] = 1; irq_req[12] = 1; irq_req[20] = 1; cyc("R6 multi set");
        cyc("R6 lowest index first");
        reti = 1; cyc("R6 reti");
        cyc("R6 next index");
        reti = 1; cyc("R6 reti");
        cyc("R8 src 20 high bank");
        // tie among non-maskable sources
        cpu_ready = 0; irq_req[2] = 1; irq_req[3] = 1; irq_req[9] = 1; cyc("R7 set");
        cpu_ready = 1; swi_strobe = 1; undef_strobe = 1; cyc("R7 swi first");
        undef_strobe = 1; cyc("R7 undef second");
        cyc("R7 src 2 third");
        cyc("R7 src 3 fourth");
        cyc("R4 src 9 held while imf off");
        // strobes ignored while busy
        cpu_ready = 0; swi_strobe = 1; undef_strobe = 1; cyc("R9 strobe ignored");
        cpu_ready = 1; cyc("R9 strobe not stored");
        // set wins over clear
        irq_req[2] = 1; cyc("R3 set");
        irq_req[2] = 1; cyc("R3 taken with new request");
        cyc("R3 taken again");
        cyc("R3 now cleared");
        // source 4 needs its extra enable; cleared ef bit blocks
        cfg(1, 0, '1, "R12 ext0 off");
        cyc("R4 src 9 taken after cfg");
        reti = 1; irq_req[4] = 1; cyc("R4 src 4 set");
        cyc("R4 src 4 blocked by ext0");
        cfg(1, 1, '1, "R4 ext0 on");
        cyc("R4 src 4 taken");
        cfg(1, 1, ~(20'b1 << 5), "R12 clear ef9");
        irq_req[9] = 1; cyc("R4 ef9 clear");
        cyc("R4 src 9 blocked by ef");
        // write overrides acceptance clear of imf
        cfg_we = 1; cfg_imf = 1; cfg_ext0_en = 1; cfg_ef = '1; cyc("R11 write with take");
        irq_req[11] = 1; cyc("R11 set");
        cyc("R11 imf from write allows take");
        // sweep the full vector map
        for (int s = 2; s <= LAST; s++) begin
            cfg(1, 1, '1, "R12 sweep cfg");
            irq_req[s] = 1; cyc("R2 sweep set");
            cyc("R8 sweep vector");
        end
        cyc("R10 final idle");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule